// File: doc/BRIEF.md
# Code-Block Stripe Scan Generator

This block produces the coordinate sequence for one code-block in the order a bit-plane block coder consumes it. The block is cut into horizontal bands four rows tall. Each band is walked column by column from left to right. Inside a column the rows are taken from top to bottom. Bands follow each other from the top of the block downward. A word-level transform that follows these coordinates can therefore hand each coefficient straight to the block coder, and no reordering buffer is needed between them.

One coordinate pair leaves the block per accepted handshake. With the consumer always ready, a 64-wide band of four rows fills exactly 256 cycles. Two 32-wide bands fill the same 256 cycles. Along with each sample the block raises a mask flag on the lowest row of its band. The flag tells the coder to treat the neighbour below as insignificant, because that neighbour belongs to the next band. Separate flags mark the final sample of each band and the final sample of the block. When the height is not a multiple of four, the last band is shortened.

Top module: `stripe_scan_gen`

## Requirements
- R1: While reset is held and right after it, `out_valid`, `below_mask`, `stripe_last` and `block_last` are all low.
- R2: A `start` pulse seen while `out_valid` is low, with a nonzero `blk_height`, makes `out_valid` high on the next cycle with `row` = 0 and `col` = 0. A `start` seen while `out_valid` is high has no effect on the running scan.
- R3: `wide_sel` = 1 selects 64 columns per band and `wide_sel` = 0 selects 32 columns. The value is captured at the accepted start.
- R4: Inside one column of a band, consecutive samples step `row` up by one, from the band's top row to its bottom row, with `col` unchanged.
- R5: After the bottom sample of a column, `col` steps by one and `row` returns to the band's top row. After the last column of a band, the next band begins at `col` = 0 on the row four below the previous band's top row.
- R6: While `out_valid` is high and `out_ready` is low, `row`, `col` and every flag hold their values, and no sample is skipped.
- R7: `below_mask` is high exactly on samples whose row is the bottom row of their band: either row mod 4 = 3, or the last row of the block.
- R8: `stripe_last` is high on the sample in the last column and bottom row of each band. `block_last` is high only on the last such sample of the block. After that sample is accepted, `out_valid` goes low.
- R9: When the height is not a multiple of four, the final band holds only the remaining rows. A block of width W and height H yields exactly W*H samples.
- R10: A `blk_height` above `MAX_H` is treated as `MAX_H`. A start with `blk_height` = 0 is ignored and `out_valid` stays low.
- R11: With `out_ready` held high, one sample is accepted in every cycle, so a block takes exactly W*H cycles from its first sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new block scan when idle |
| wide_sel | input | 1 | 1: 64 columns, 0: 32 columns |
| blk_height | input | H_BITS (7) | Block height in rows |
| out_ready | input | 1 | Consumer accepts the current sample |
| out_valid | output | 1 | A sample coordinate is presented |
| row | output | ROW_BITS (6) | Row index of the sample |
| col | output | COL_BITS (6) | Column index of the sample |
| below_mask | output | 1 | Neighbour below lies in the next band |
| stripe_last | output | 1 | Final sample of the current band |
| block_last | output | 1 | Final sample of the block |

## Verification
The bench builds the block with its defaults: 64 and 32 columns and a maximum height of 64. These values make full-size blocks, shortened final bands of one to three rows, and the height clamp all reachable within a short run. The bench checks every accepted coordinate and flag against a nested band/column/row walk that it computes on its own. It also inserts stalls, sends starts while a scan is running, and sends zero heights, to cover the ignore cases.

// File: rtl/stripe_scan_pkg.sv
package stripe_scan_pkg;

  localparam int STRIPE_ROWS = 4;

  function automatic int cols_for(logic wide, int wide_w, int narrow_w);
    return wide ? wide_w : narrow_w;
  endfunction

  function automatic int clamp_height(int h, int max_h);
    return (h > max_h) ? max_h : h;
  endfunction

  // bottom row of its band: full band edge or last row of the block
  function automatic logic is_band_bottom(int r, int height);
    return ((r % STRIPE_ROWS) == STRIPE_ROWS - 1) || (r + 1 == height);
  endfunction

  function automatic logic is_final_band(int base, int height);
    return (base + STRIPE_ROWS) >= height;
  endfunction

endpackage

// File: rtl/scan_col_ctr.sv
module scan_col_ctr #(
  parameter int COL_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                step,
  input  logic [COL_BITS-1:0] last_col,
  output logic [COL_BITS-1:0] col,
  output logic                at_end
);

  logic [COL_BITS-1:0] col_q;

  assign at_end = (col_q == last_col);
  assign col    = col_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      col_q <= '0;
    else if (clear)
      col_q <= '0;
    else if (step)
      col_q <= at_end ? '0 : col_q + 1'b1;
  end

endmodule

// File: rtl/scan_band_ctr.sv
module scan_band_ctr
  import stripe_scan_pkg::*;
#(
  parameter int ROW_BITS = 6,
  parameter int H_BITS   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                step_lane,
  input  logic                wrap_lane,
  input  logic                next_band,
  input  logic [H_BITS-1:0]   height,
  output logic [ROW_BITS-1:0] row,
  output logic                band_bottom,
  output logic                final_band
);

  localparam int LANE_BITS = $clog2(STRIPE_ROWS);

  logic [H_BITS-1:0]    base_q;
  logic [LANE_BITS-1:0] lane_q;
  logic [H_BITS-1:0]    abs_row;

  assign abs_row     = base_q + H_BITS'(lane_q);
  assign row         = ROW_BITS'(abs_row);
  assign band_bottom = is_band_bottom(int'(abs_row), int'(height));
  assign final_band  = is_final_band(int'(base_q), int'(height));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lane_q <= '0;
    end else if (clear) begin
      base_q <= '0;
      lane_q <= '0;
    end else if (next_band) begin
      base_q <= base_q + H_BITS'(STRIPE_ROWS);
      lane_q <= '0;
    end else if (wrap_lane) begin
      lane_q <= '0;
    end else if (step_lane) begin
      lane_q <= lane_q + 1'b1;
    end
  end

endmodule

// File: rtl/stripe_scan_gen.sv
module stripe_scan_gen
  import stripe_scan_pkg::*;
#(
  parameter int WIDE_W   = 64,
  parameter int NARROW_W = 32,
  parameter int MAX_H    = 64,
  localparam int COL_BITS = $clog2(WIDE_W),
  localparam int ROW_BITS = $clog2(MAX_H),
  localparam int H_BITS   = $clog2(MAX_H + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide_sel,
  input  logic [H_BITS-1:0]   blk_height,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [ROW_BITS-1:0] row,
  output logic [COL_BITS-1:0] col,
  output logic                below_mask,
  output logic                stripe_last,
  output logic                block_last
);

  logic              run_q;
  logic              wide_q;
  logic [H_BITS-1:0] height_q;

  // named internal events, used by the bound checker
  logic start_take;
  logic fire;
  logic band_bottom;
  logic col_end;
  logic final_band;
  logic adv_lane, adv_col, adv_band, scan_done;
  logic [COL_BITS-1:0] last_col;

  assign start_take = start && !run_q && (blk_height != '0);
  assign fire       = run_q && out_ready;
  assign adv_lane   = fire && !band_bottom;
  assign adv_col    = fire && band_bottom && !col_end;
  assign adv_band   = fire && band_bottom && col_end && !final_band;
  assign scan_done  = fire && band_bottom && col_end && final_band;
  assign last_col   = COL_BITS'(cols_for(wide_q, WIDE_W, NARROW_W) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      wide_q   <= 1'b0;
      height_q <= '0;
    end else if (start_take) begin
      run_q    <= 1'b1;
      wide_q   <= wide_sel;
      height_q <= H_BITS'(clamp_height(int'(blk_height), MAX_H));
    end else if (scan_done) begin
      run_q    <= 1'b0;
    end
  end

  scan_col_ctr #(.COL_BITS(COL_BITS)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_take),
    .step     (adv_col || adv_band),
    .last_col (last_col),
    .col      (col),
    .at_end   (col_end)
  );

  scan_band_ctr #(.ROW_BITS(ROW_BITS), .H_BITS(H_BITS)) u_band (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (start_take),
    .step_lane   (adv_lane),
    .wrap_lane   (adv_col),
    .next_band   (adv_band),
    .height      (height_q),
    .row         (row),
    .band_bottom (band_bottom),
    .final_band  (final_band)
  );

  assign out_valid   = run_q;
  assign below_mask  = run_q && band_bottom;
  assign stripe_last = run_q && band_bottom && col_end;
  assign block_last  = stripe_last && final_band;

endmodule

// File: rtl/stripe_scan_chk.sv
module stripe_scan_chk #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_take,
  input logic                out_valid,
  input logic                out_ready,
  input logic [ROW_BITS-1:0] row,
  input logic [COL_BITS-1:0] col,
  input logic                below_mask,
  input logic                stripe_last,
  input logic                block_last
);

  logic hs;
  assign hs = out_valid && out_ready;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !below_mask && !stripe_last && !block_last);

  a_r2_first_sample: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> out_valid && row == '0 && col == '0);

  a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !below_mask |=> out_valid && row == $past(row) + 1'b1 && col == $past(col));

  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    hs && below_mask && !stripe_last |=>
      out_valid && col == $past(col) + 1'b1 && row[1:0] == 2'b00 && (row >> 2) == ($past(row) >> 2));

  a_r5_band_step: assert property (@(posedge clk) disable iff (!rst_n)
    hs && stripe_last && !block_last |=> out_valid && col == '0 && row[1:0] == 2'b00 && row > $past(row));

  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(row) && $stable(col) && $stable(below_mask));

  a_r7_last_implies_mask: assert property (@(posedge clk) disable iff (!rst_n)
    stripe_last |-> below_mask);

  a_r8_block_end: assert property (@(posedge clk) disable iff (!rst_n)
    hs && block_last |=> !out_valid);

endmodule

bind stripe_scan_gen stripe_scan_chk #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_take  (start_take),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .row         (row),
  .col         (col),
  .below_mask  (below_mask),
  .stripe_last (stripe_last),
  .block_last  (block_last)
);

// File: tb/sim_stripe_scan_gen.sv
module sim_stripe_scan_gen;

  localparam int CLK_NS   = 10;
  localparam int WIDE_W   = 64;
  localparam int NARROW_W = 32;
  localparam int MAX_H    = 64;
  localparam int H_BITS   = 7;
  localparam int ROW_BITS = 6;
  localparam int COL_BITS = 6;

  localparam int NVEC = 6;
  localparam int VEC_W [NVEC] = '{1, 0, 1, 0, 1, 0};
  localparam int VEC_H [NVEC] = '{4, 8, 6, 3, 1, 64};
  localparam int VEC_N [NVEC] = '{256, 256, 384, 96, 64, 2048};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic wide_sel = 1'b0;
  logic [H_BITS-1:0] blk_height = '0;
  logic out_ready = 1'b1;
  logic out_valid;
  logic [ROW_BITS-1:0] row;
  logic [COL_BITS-1:0] col;
  logic below_mask, stripe_last, block_last;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stripe_scan_gen #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .MAX_H(MAX_H)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wide_sel(wide_sel),
    .blk_height(blk_height), .out_ready(out_ready), .out_valid(out_valid),
    .row(row), .col(col), .below_mask(below_mask),
    .stripe_last(stripe_last), .block_last(block_last)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pack_obs(bit v, int r, int c, bit m, bit sl, bit bl);
    return v * 1000000 + r * 1000 + c * 8 + m * 4 + sl * 2 + bl;
  endfunction

  // walk one block; the expected order comes from nested band/column/row loops
  task automatic run_scan(bit wide, int h_in, int h_eff, int exp_n, bit stall, bit kick);
    int w = wide ? WIDE_W : NARROW_W;
    int taken = 0;
    int t0;
    wide_sel   = wide;
    blk_height = H_BITS'(h_in);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
    chk(out_valid && row == 0 && col == 0, "R2 first sample at origin",
        pack_obs(out_valid, int'(row), int'(col), 0, 0, 0), pack_obs(1, 0, 0, 0, 0, 0));
    for (int s = 0; s < h_eff; s += 4) begin
      for (int c = 0; c < w; c++) begin
        for (int r = s; r < s + 4 && r < h_eff; r++) begin
          bit m, sl, bl;
          int act, exp;
          if (stall && (taken % 5 == 2)) begin
            int pr = int'(row);
            int pc = int'(col);
            out_ready = 1'b0;
            @(negedge clk);
            chk(out_valid && int'(row) == pr && int'(col) == pc, "R6 stall holds position",
                int'(row) * 1000 + int'(col), pr * 1000 + pc);
            out_ready = 1'b1;
          end
          if (kick && taken == 10) begin
            start      = 1'b1;
            blk_height = H_BITS'(2);
            wide_sel   = ~wide;
          end
          m   = ((r % 4) == 3) || (r == h_eff - 1);
          sl  = m && (c == w - 1);
          bl  = sl && (s + 4 >= h_eff);
          act = pack_obs(out_valid, int'(row), int'(col), below_mask, stripe_last, block_last);
          exp = pack_obs(1, r, c, m, sl, bl);
          chk(act == exp, "R3/R4/R5/R7/R8 sample order and flags", act, exp);
          @(negedge clk);
          start = 1'b0;
          taken++;
        end
      end
    end
    chk(!out_valid, "R8 idle after block end", int'(out_valid), 0);
    chk(taken == exp_n, "R9 sample count", taken, exp_n);
    if (!stall)
      chk(cyc - t0 == exp_n, "R11 one sample per cycle", cyc - t0, exp_n);
  endtask

  initial begin
    #(CLK_NS * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !below_mask && !stripe_last && !block_last, "R1 quiet in reset",
        pack_obs(out_valid, 0, 0, below_mask, stripe_last, block_last), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !below_mask && !stripe_last && !block_last, "R1 quiet after reset",
        pack_obs(out_valid, 0, 0, below_mask, stripe_last, block_last), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_scan(VEC_W[i][0], VEC_H[i], VEC_H[i], VEC_N[i], (i == 2) || (i == 3), 1'b0);
      @(negedge clk);
    end

    // R2: start during a running scan must not disturb it
    run_scan(1'b1, 8, 8, 512, 1'b0, 1'b1);
    @(negedge clk);

    // R10: zero height is ignored
    wide_sel = 1'b1; blk_height = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!out_valid, "R10 zero height ignored", int'(out_valid), 0);
    @(negedge clk);
    chk(!out_valid, "R10 zero height stays idle", int'(out_valid), 0);

    // R10: height above the maximum is clamped
    run_scan(1'b0, 100, MAX_H, NARROW_W * MAX_H, 1'b0, 1'b0);
    @(negedge clk);

    // R3: narrow block with a two-row final band and stalls
    run_scan(1'b0, 10, 10, 320, 1'b1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule